// File: doc/BRIEF.md
# Compute Dispatch Wave Splitter

The wave splitter turns compute dispatch commands into 64-lane wavefronts for a set of compute units. Each of several command queues holds at most one command. A command gives the number of workgroups and the threads per workgroup, both encoded minus one. At each workgroup boundary the splitter picks the next queue with a pending command, round-robin. It then picks a compute unit, round-robin among the units that report ready, and streams that workgroup's waves to the unit one per cycle. A wave leaves only when the chosen unit accepts it.

Each wave descriptor carries the source queue, the workgroup id, the wave index inside the workgroup, the dispatch-wide id of the wave's first thread, and a 64-bit active-lane mask. Every wave is full except possibly the last wave of a workgroup, whose mask keeps only the remaining low lanes. A one-cycle done pulse, tagged with the queue, marks the acceptance of a command's final wave.

The control is a two-state machine. `S_IDLE` waits for a pending queue and a ready unit. It moves to `S_EMIT` on a pick, which latches the queue, the unit and wave index 0. `S_EMIT` stays put while the unit stalls. On an accept that is not the last wave of the group it also stays and steps the wave index. On the accept of the group's last wave it returns to `S_IDLE`, which advances the queue's group and frees the queue after its final group.

Top module: `wave_splitter`

## Requirements
- R1: After reset no wave is valid, every queue reports ready, and done is low.
- R2: A workgroup of S threads yields ceil(S/64) waves with wave_idx 0,1,2,… in order. Each wave carries the group id, and wave_tid equals group*S + wave_idx*64.
- R3: Mask bit i stands for lane i. Every wave except the last of a workgroup has all 64 bits set. The last wave sets exactly bits 0 to (S-1) mod 64.
- R4: All waves of a workgroup go to the same compute unit, and that unit reported ready when it was picked. Units are searched round-robin, starting one past the last unit granted (unit 0 after reset).
- R5: While the chosen unit holds its accept bit low, the descriptor (valid, unit, tid, mask) stays unchanged.
- R6: At most one wave is issued per cycle. The next wave of the same group is offered the cycle after an accept. The first wave of the next group is offered two cycles after the previous group's last accept.
- R7: Queues with pending commands are served round-robin, one workgroup at a time, searching from one past the last queue served (queue 0 after reset).
- R8: q_ready of a queue is high exactly while it holds no command. A command is captured when q_valid and q_ready are both high, with field values equal to count minus one. A queue stays busy until its last wave is accepted.
- R9: done pulses for one cycle, with done_queue naming the queue, in the cycle after the accept of a command's last wave.
- R10: Accept bits of compute units other than the chosen one have no effect.
- R11: While no compute unit is ready, no wave is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | NQ | Command offered per queue |
| q_ready | output | NQ | Queue slot free |
| q_groups_m1 | input | NQ*GRP_W | Per queue: workgroup count minus one |
| q_gsize_m1 | input | NQ*GSZ_W | Per queue: threads per workgroup minus one |
| cu_ready | input | NCU | Unit can take a new workgroup |
| cu_accept | input | NCU | Unit accepts the offered wave |
| wave_valid | output | 1 | Descriptor valid |
| wave_cu | output | CU_W | Target compute unit |
| wave_queue | output | Q_W | Source queue |
| wave_group | output | GRP_W | Workgroup id |
| wave_idx | output | WIDX_W | Wave index in the workgroup |
| wave_tid | output | TID_W | First thread id of the wave |
| wave_mask | output | LANES | Active-lane mask |
| done | output | 1 | Command finished pulse |
| done_queue | output | Q_W | Queue whose command finished |

## Verification
A command written on one edge gets its unit picked on the next edge. Its first wave is offered after that pick, and each further wave of the group follows one cycle after an accept. The next group's first wave follows two cycles after the previous group's last accept, and done follows one cycle after the final accept. Inputs change one nanosecond after the rising edge, and the monitor samples at the falling edge. There it counts cycles and pops one scoreboard entry per accepted wave. Each entry records the expected distance from the previous handshake, so both the wave spacing and the done timing are checked against cycle counts rather than by waiting for an event.

// File: rtl/wsplit_pkg.sv
package wsplit_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_EMIT = 1'b1
    } split_state_t;
endpackage

// File: rtl/wsplit_rr_arb.sv
module wsplit_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 adv,
    output logic                 any,
    output logic [$clog2(N)-1:0] gnt_idx
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr;
    logic [IW:0]   sum;

    always_comb begin
        any     = 1'b0;
        gnt_idx = '0;
        sum     = '0;
        for (int off = N - 1; off >= 0; off--) begin
            sum = {1'b0, ptr} + (IW + 1)'(off);
            if (sum >= (IW + 1)'(N)) sum = sum - (IW + 1)'(N);
            if (req[sum[IW-1:0]]) begin
                any     = 1'b1;
                gnt_idx = sum[IW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (adv && any)
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end
endmodule

// File: rtl/wsplit_mask_gen.sv
module wsplit_mask_gen #(
    parameter int LANES = 64
) (
    input  logic                       is_last,
    input  logic [$clog2(LANES)-1:0]   last_lane,
    output logic [LANES-1:0]           mask
);
    localparam int SH = $clog2(LANES);
    logic [SH-1:0] drop;

    always_comb begin
        drop = ~last_lane;
        mask = is_last ? ({LANES{1'b1}} >> drop) : {LANES{1'b1}};
    end
endmodule

// File: rtl/wave_splitter.sv
module wave_splitter
    import wsplit_pkg::*;
#(
    parameter int NQ      = 4,
    parameter int NCU     = 4,
    parameter int LANES   = 64,
    parameter int MAX_GSZ = 1024,
    parameter int GRP_W   = 16,
    localparam int GSZ_W  = $clog2(MAX_GSZ),
    localparam int LANE_SH = $clog2(LANES),
    localparam int WIDX_W = GSZ_W - LANE_SH,
    localparam int TID_W  = GRP_W + GSZ_W,
    localparam int Q_W    = $clog2(NQ),
    localparam int CU_W   = $clog2(NCU)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NQ-1:0]          q_valid,
    output logic [NQ-1:0]          q_ready,
    input  logic [NQ*GRP_W-1:0]    q_groups_m1,
    input  logic [NQ*GSZ_W-1:0]    q_gsize_m1,
    input  logic [NCU-1:0]         cu_ready,
    input  logic [NCU-1:0]         cu_accept,
    output logic                   wave_valid,
    output logic [CU_W-1:0]        wave_cu,
    output logic [Q_W-1:0]         wave_queue,
    output logic [GRP_W-1:0]       wave_group,
    output logic [WIDX_W-1:0]      wave_idx,
    output logic [TID_W-1:0]       wave_tid,
    output logic [LANES-1:0]       wave_mask,
    output logic                   done,
    output logic [Q_W-1:0]         done_queue
);
    split_state_t state, state_nxt;

    logic [NQ-1:0]             busy;
    logic [NQ-1:0][GSZ_W-1:0]  sz_m1;
    logic [NQ-1:0][GRP_W-1:0]  grps_m1;
    logic [NQ-1:0][GRP_W-1:0]  nxt_grp;
    logic [NQ-1:0][TID_W-1:0]  base;

    logic [Q_W-1:0]    cur_q;
    logic [CU_W-1:0]   cur_cu;
    logic [WIDX_W-1:0] widx;
    logic              done_r;
    logic [Q_W-1:0]    done_q_r;

    logic            q_any, cu_any, pick, acc, last_wave, last_group, grp_end;
    logic [Q_W-1:0]  q_gnt;
    logic [CU_W-1:0] cu_gnt;

    wsplit_rr_arb #(.N(NQ)) u_q_arb (
        .clk(clk), .rst_n(rst_n), .req(busy), .adv(pick),
        .any(q_any), .gnt_idx(q_gnt)
    );

    wsplit_rr_arb #(.N(NCU)) u_cu_arb (
        .clk(clk), .rst_n(rst_n), .req(cu_ready), .adv(pick),
        .any(cu_any), .gnt_idx(cu_gnt)
    );

    wsplit_mask_gen #(.LANES(LANES)) u_mask (
        .is_last(last_wave), .last_lane(sz_m1[cur_q][LANE_SH-1:0]),
        .mask(wave_mask)
    );

    always_comb begin
        pick       = (state == S_IDLE) && q_any && cu_any;
        acc        = (state == S_EMIT) && cu_accept[cur_cu];
        last_wave  = (widx == sz_m1[cur_q][GSZ_W-1:LANE_SH]);
        last_group = (nxt_grp[cur_q] == grps_m1[cur_q]);
        grp_end    = acc && last_wave;
    end

    // Per-queue command slots
    for (genvar i = 0; i < NQ; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy[i]    <= 1'b0;
                sz_m1[i]   <= '0;
                grps_m1[i] <= '0;
                nxt_grp[i] <= '0;
                base[i]    <= '0;
            end else if (q_valid[i] && !busy[i]) begin
                busy[i]    <= 1'b1;
                sz_m1[i]   <= q_gsize_m1[i*GSZ_W +: GSZ_W];
                grps_m1[i] <= q_groups_m1[i*GRP_W +: GRP_W];
                nxt_grp[i] <= '0;
                base[i]    <= '0;
            end else if (grp_end && cur_q == Q_W'(i)) begin
                nxt_grp[i] <= nxt_grp[i] + 1'b1;
                base[i]    <= base[i] + TID_W'(sz_m1[i]) + 1'b1;
                if (last_group) busy[i] <= 1'b0;
            end
        end
    end

    // State register and per-group datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cur_q    <= '0;
            cur_cu   <= '0;
            widx     <= '0;
            done_r   <= 1'b0;
            done_q_r <= '0;
        end else begin
            state  <= state_nxt;
            done_r <= grp_end && last_group;
            if (grp_end) done_q_r <= cur_q;
            if (pick) begin
                cur_q  <= q_gnt;
                cur_cu <= cu_gnt;
                widx   <= '0;
            end else if (acc && !last_wave) begin
                widx <= widx + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (pick) state_nxt = S_EMIT;
            S_EMIT: if (grp_end) state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        q_ready    = ~busy;
        wave_valid = (state == S_EMIT);
        wave_cu    = cur_cu;
        wave_queue = cur_q;
        wave_group = nxt_grp[cur_q];
        wave_idx   = widx;
        wave_tid   = base[cur_q] + TID_W'({widx, {LANE_SH{1'b0}}});
        done       = done_r;
        done_queue = done_q_r;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (wave_valid && !cu_accept[wave_cu]) |=> (wave_valid && $stable(wave_tid) && $stable(wave_mask) && $stable(wave_cu))); // R5
    AST_GROUP_SAME_CU: assert property (@(posedge clk) disable iff (!rst_n) (wave_valid && wave_idx != '0) |-> (wave_cu == $past(wave_cu))); // R4
    AST_PICK_READY_CU: assert property (@(posedge clk) disable iff (!rst_n) $rose(wave_valid) |-> (($past(cu_ready) >> wave_cu) & NCU'(1)) != '0); // R4
    AST_MASK_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n) wave_valid |-> (wave_mask[0] && ((wave_mask & (wave_mask + 1'b1)) == '0))); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R9
    AST_SRC_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wave_valid |-> !q_ready[wave_queue]); // R8
endmodule

// File: tb/wave_splitter_tb_top.sv
module wave_splitter_tb_top;
    localparam int NQ = 4, NCU = 4, GRP_W = 16, GSZ_W = 10;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                rst_n;
    logic [NQ-1:0]       q_valid, q_ready;
    logic [NQ*GRP_W-1:0] q_groups_m1;
    logic [NQ*GSZ_W-1:0] q_gsize_m1;
    logic [NCU-1:0]      cu_ready, cu_accept;
    logic                wave_valid, done;
    logic [1:0]          wave_cu, wave_queue, done_queue;
    logic [15:0]         wave_group;
    logic [3:0]          wave_idx;
    logic [25:0]         wave_tid;
    logic [63:0]         wave_mask;

    wave_splitter dut_i (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
        .q_groups_m1(q_groups_m1), .q_gsize_m1(q_gsize_m1),
        .cu_ready(cu_ready), .cu_accept(cu_accept),
        .wave_valid(wave_valid), .wave_cu(wave_cu), .wave_queue(wave_queue),
        .wave_group(wave_group), .wave_idx(wave_idx), .wave_tid(wave_tid),
        .wave_mask(wave_mask), .done(done), .done_queue(done_queue)
    );

    typedef struct {
        int q; int cu; int grp; int idx; longint tid; logic [63:0] mask; int gap;
    } item_t;

    item_t sb[$];
    item_t e;
    int checks = 0, fails = 0;
    int cyc = 0, last_hs = 0, done_cnt = 0, last_done_q = -1, mptr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int pick_cu(input logic [3:0] rdy);
        for (int off = 0; off < NCU; off++) begin
            int c = (mptr + off) % NCU;
            if (rdy[c]) begin
                mptr = (c + 1) % NCU;
                return c;
            end
        end
        return -1;
    endfunction

    // Driver side of the scoreboard: expected waves of one workgroup
    task automatic push_group(input int q, input int grp, input int s,
                              input logic [3:0] rdy, input int first_gap);
        int n = (s + 63) / 64;
        int c = pick_cu(rdy);
        for (int i = 0; i < n; i++) begin
            item_t it;
            int lanes = (s - i * 64 >= 64) ? 64 : s - i * 64;
            it.q = q; it.cu = c; it.grp = grp; it.idx = i;
            it.tid = longint'(grp) * s + i * 64;
            it.mask = (lanes == 64) ? {64{1'b1}} : ((64'd1 << lanes) - 64'd1);
            it.gap = (i == 0) ? first_gap : 1;
            sb.push_back(it);
        end
    endtask

    task automatic load(input int q, input int g_m1, input int s_m1);
        q_groups_m1[q*GRP_W +: GRP_W] = GRP_W'(g_m1);
        q_gsize_m1[q*GSZ_W +: GSZ_W]  = GSZ_W'(s_m1);
        q_valid[q] = 1'b1;
        @(posedge clk); #1;
        q_valid = '0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && sb.size() != 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
        chk(sb.size() == 0, "R2", "waves still expected", sb.size(), 0);
    endtask

    // Monitor: pops one expected item per accepted wave
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (done) begin
                chk(cyc == last_hs + 1, "R9", "done cycle", cyc, last_hs + 1);
                done_cnt++;
                last_done_q = done_queue;
            end
            if (wave_valid && cu_accept[wave_cu]) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R2", "unexpected wave tid", wave_tid, 0);
                end else begin
                    e = sb.pop_front();
                    chk(wave_group == e.grp, "R2", "group", wave_group, e.grp);
                    chk(wave_idx == e.idx, "R2", "wave index", wave_idx, e.idx);
                    chk(wave_tid == e.tid, "R2", "start tid", wave_tid, e.tid);
                    chk(wave_mask == e.mask, "R3", "mask", wave_mask, e.mask);
                    chk(wave_cu == e.cu, "R4", "compute unit", wave_cu, e.cu);
                    chk(wave_queue == e.q, "R7", "queue", wave_queue, e.q);
                    if (e.gap != 0)
                        chk(cyc - last_hs == e.gap, "R6", "wave spacing", cyc - last_hs, e.gap);
                end
                last_hs = cyc;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int dc0;
        logic [25:0] hold_tid;
        logic [63:0] hold_mask;
        rst_n = 1'b0; q_valid = '0; q_groups_m1 = '0; q_gsize_m1 = '0;
        cu_ready = '0; cu_accept = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(wave_valid == 1'b0, "R1", "valid in reset", wave_valid, 0);
        chk(q_ready == 4'hF, "R1", "q_ready in reset", q_ready, 4'hF);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        cu_ready = 4'hF; cu_accept = 4'hF;

        // Full waves, four groups of 64
        dc0 = done_cnt;
        for (int g = 0; g < 4; g++) push_group(0, g, 64, 4'hF, g == 0 ? 0 : 2);
        load(0, 3, 63);
        drain();
        chk(done_cnt == dc0 + 1, "R9", "done count", done_cnt, dc0 + 1);
        chk(last_done_q == 0, "R9", "done queue", last_done_q, 0);

        // Partial last wave: groups of 100 threads
        push_group(0, 0, 100, 4'hF, 0);
        push_group(0, 1, 100, 4'hF, 2);
        load(0, 1, 99);
        drain();

        // 128x128 threads as 16 groups of 1024: 256 waves
        dc0 = done_cnt;
        for (int g = 0; g < 16; g++) push_group(0, g, 1024, 4'hF, 0);
        load(0, 15, 1023);
        drain();
        chk(done_cnt == dc0 + 1, "R9", "done after 256 waves", done_cnt, dc0 + 1);

        // Stall on the chosen unit, other units accepting
        cu_ready = 4'b0100; cu_accept = 4'b1011;
        dc0 = done_cnt;
        push_group(0, 0, 64, 4'b0100, 0);
        load(0, 0, 63);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wave_valid == 1'b1, "R5", "valid during stall", wave_valid, 1);
        chk(wave_cu == 2, "R4", "only ready unit", wave_cu, 2);
        hold_tid = wave_tid; hold_mask = wave_mask;
        repeat (4) @(negedge clk);
        chk(wave_valid == 1'b1, "R10", "other accepts ignored", wave_valid, 1);
        chk(wave_tid == hold_tid, "R5", "tid held", wave_tid, hold_tid);
        chk(wave_mask == hold_mask, "R5", "mask held", wave_mask, hold_mask);
        chk(done_cnt == dc0, "R10", "no done while stalled", done_cnt, dc0);
        @(posedge clk); #1;
        cu_accept = 4'hF; cu_ready = 4'hF;
        drain();

        // No ready unit: nothing offered, queue stays busy
        cu_ready = 4'h0;
        push_group(0, 0, 64, 4'b0001, 0);
        load(0, 0, 63);
        repeat (10) @(negedge clk);
        chk(wave_valid == 1'b0, "R11", "no wave without ready unit", wave_valid, 0);
        chk(q_ready[0] == 1'b0, "R8", "busy queue not ready", q_ready[0], 0);
        chk(q_ready[1] == 1'b1, "R8", "idle queue ready", q_ready[1], 1);
        @(posedge clk); #1;
        cu_ready = 4'b0001;
        drain();
        cu_ready = 4'hF;

        // Two queues at once: groups alternate
        dc0 = done_cnt;
        push_group(1, 0, 64, 4'hF, 0);
        push_group(2, 0, 64, 4'hF, 2);
        push_group(1, 1, 64, 4'hF, 2);
        push_group(2, 1, 64, 4'hF, 2);
        q_groups_m1[1*GRP_W +: GRP_W] = 16'd1; q_gsize_m1[1*GSZ_W +: GSZ_W] = 10'd63;
        q_groups_m1[2*GRP_W +: GRP_W] = 16'd1; q_gsize_m1[2*GSZ_W +: GSZ_W] = 10'd63;
        q_valid = 4'b0110;
        @(posedge clk); #1;
        q_valid = '0;
        drain();
        chk(done_cnt == dc0 + 2, "R7", "both commands done", done_cnt, dc0 + 2);
        chk(last_done_q == 2, "R9", "last done queue", last_done_q, 2);
        chk(q_ready == 4'hF, "R8", "all queues free", q_ready, 4'hF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule